// File: doc/BRIEF.md
# Local bus hold arbiter with lock suppression

This block decides who owns the local bus: the processor or an external master. The external master raises an asynchronous hold request. The arbiter first passes that request through a synchronizer chain. It then waits for a clock in which three things are true together: the instruction-boundary strobe is high, no locked sequence is in progress, and the bus interface reports idle. In that clock it leaves processor ownership. Float enable rises first and tells the bus interface to tri-state its data and control outputs. One clock later, hold acknowledge rises, so the external master only sees the grant after the outputs have stopped driving.

When the request drops, the arbiter withdraws hold acknowledge first. It keeps the outputs floated for one more clock and then hands the bus back to the processor. If the request vanishes during the single floating clock before the grant, the arbiter goes straight to the release path and never raises acknowledge.

The controller has four states:
- `ST_OWN`: the processor drives the bus.
- `ST_FLOAT`: outputs are tri-stated and the grant is not yet visible.
- `ST_GRANTED`: the external master owns the bus.
- `ST_RECLAIM`: acknowledge has been withdrawn and outputs are still floated.

It has five transitions:
- OWN→FLOAT when the synchronized request and all qualifiers are present.
- FLOAT→GRANTED while the request persists.
- FLOAT→RECLAIM if the request has gone.
- GRANTED→RECLAIM when the request drops.
- RECLAIM→OWN unconditionally.

Top module: `hold_arbiter`

## Requirements
- R1: While reset is low, and on the first clock after reset, `hold_ack` and `float_en` are 0 whatever the other inputs are, including a lock input held high.
- R2: The request passes through SYNC_STAGES flops (default 2). With all qualifiers true, `float_en` rises at the third rising edge after `hold_req` goes high, and not earlier.
- R3: The arbiter leaves `ST_OWN` only at an edge where `insn_boundary` is 1.
- R4: No grant starts at an edge where `lock_active` is 1.
- R5: No grant starts at an edge where `bus_idle` is 0.
- R6: `float_en` rises one clock before `hold_ack`. Both stay 1 for as long as the request is held.
- R7: Once `ST_GRANTED` is reached, `lock_active` and `insn_boundary` have no effect, and `hold_ack` stays 1.
- R8: After `hold_req` drops, `hold_ack` falls at the third edge while `float_en` stays 1. `float_en` falls at the fourth edge.
- R9: If the synchronized request is gone while in `ST_FLOAT`, the arbiter goes to `ST_RECLAIM`. `hold_ack` is never raised and `float_en` falls one clock later.
- R10: After a full release, a new request is granted with the same three-edge latency as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_req | input | 1 | Asynchronous bus request from the external master |
| insn_boundary | input | 1 | High in a clock where the processor sits between instructions |
| lock_active | input | 1 | High while a locked sequence is in progress |
| bus_idle | input | 1 | High when no processor bus cycle is running |
| hold_ack | output | 1 | Grant to the external master |
| float_en | output | 1 | Orders the bus interface to tri-state data and control outputs |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. This fixes grant and release latencies at three and four edges, so every transition is checked at its exact clock. The bench sweeps all eight combinations of boundary strobe, lock and idle at the decision edge and computes the expected grant from their logical AND. The two-stage chain also makes it possible to time a request drop that lands exactly on the floating clock, which exercises the aborted-grant path.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

    typedef enum logic [1:0] {
        ST_OWN     = 2'd0,
        ST_FLOAT   = 2'd1,
        ST_GRANTED = 2'd2,
        ST_RECLAIM = 2'd3
    } arb_state_t;

    typedef struct packed {
        logic ack;
        logic flt;
    } arb_out_t;

endpackage

// File: rtl/hold_req_sync.sv
module hold_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_out = chain[LAST];
endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
    import hold_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic insn_boundary,
    input  logic lock_active,
    input  logic bus_idle,
    output logic hold_ack,
    output logic float_en
);
    arb_state_t state_q, state_d;
    arb_out_t   outs;
    logic       safe_point;

    assign safe_point = insn_boundary && !lock_active && bus_idle;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWN:     if (req_s && safe_point) state_d = ST_FLOAT;
            ST_FLOAT:   state_d = req_s ? ST_GRANTED : ST_RECLAIM;
            ST_GRANTED: if (!req_s) state_d = ST_RECLAIM;
            ST_RECLAIM: state_d = ST_OWN;
            default:    state_d = ST_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OWN;
        else        state_q <= state_d;
    end

    always_comb begin
        outs = '0;
        unique case (state_q)
            ST_OWN:     outs = '{ack: 1'b0, flt: 1'b0};
            ST_FLOAT:   outs = '{ack: 1'b0, flt: 1'b1};
            ST_GRANTED: outs = '{ack: 1'b1, flt: 1'b1};
            ST_RECLAIM: outs = '{ack: 1'b0, flt: 1'b1};
            default:    outs = '0;
        endcase
    end

    assign hold_ack = outs.ack;
    assign float_en = outs.flt;

    // R3 R4 R5: a grant starts only from a qualified edge
    p_grant_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(float_en) |-> $past(req_s && insn_boundary && !lock_active && bus_idle))
        else $error("grant started at an unqualified edge");

    // R6: acknowledge follows float by one clock
    p_float_before_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(float_en))
        else $error("ack rose without prior float");

    // R8: outputs still floated when acknowledge falls
    p_ack_falls_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> float_en)
        else $error("float dropped together with ack");

    // R8: float released only after acknowledge was already low
    p_float_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(float_en) |-> $past(!hold_ack))
        else $error("float fell while ack still high");

    // R9: acknowledge rises only when the request was still present
    p_ack_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(req_s))
        else $error("ack raised after request vanished");
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic insn_boundary,
    input  logic lock_active,
    input  logic bus_idle,
    output logic hold_ack,
    output logic float_en
);
    logic req_s;

    hold_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hold_req),
        .sync_out (req_s)
    );

    hold_arb_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_s         (req_s),
        .insn_boundary (insn_boundary),
        .lock_active   (lock_active),
        .bus_idle      (bus_idle),
        .hold_ack      (hold_ack),
        .float_en      (float_en)
    );

    // R1: nothing granted on the first clock out of reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!hold_ack && !float_en))
        else $error("outputs active right after reset");
endmodule

// File: tb/hold_arbiter_bench.sv
module hold_arbiter_bench;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n, hold_req, insn_boundary, lock_active, bus_idle;
    logic hold_ack, float_en;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hold_arbiter u_hold_arbiter (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req),
        .insn_boundary(insn_boundary), .lock_active(lock_active),
        .bus_idle(bus_idle), .hold_ack(hold_ack), .float_en(float_en)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    initial begin
        rst_n = 0; hold_req = 1; lock_active = 1; insn_boundary = 1; bus_idle = 1;
        @(negedge clk);
        step(3);
        chk("R1 ack in reset", hold_ack, 1'b0);
        chk("R1 float in reset", float_en, 1'b0);
        rst_n = 1; hold_req = 0; lock_active = 0; insn_boundary = 0;
        step(1);
        chk("R1 ack after reset", hold_ack, 1'b0);
        chk("R1 float after reset", float_en, 1'b0);
        step(2);

        // R2: latency with all qualifiers true
        hold_req = 1; insn_boundary = 1;
        step(1); chk("R2 edge1 float", float_en, 1'b0);
        step(1); chk("R2 edge2 float", float_en, 1'b0);
        step(1); chk("R2 edge3 float", float_en, 1'b1);
        chk("R6 ack lags float", hold_ack, 1'b0);
        step(1); chk("R6 ack rises", hold_ack, 1'b1);
        hold_req = 0;
        step(4); chk("R8 release done", float_en, 1'b0);

        // R10: regrant with the same latency
        hold_req = 1;
        step(2); chk("R10 no early regrant", float_en, 1'b0);
        step(1); chk("R10 regrant float", float_en, 1'b1);
        hold_req = 0; insn_boundary = 0;
        step(4); chk("R10 released", float_en, 1'b0);

        // R3 R4 R5: sweep qualifiers at the decision edge
        for (int c = 0; c < 8; c++) begin
            logic b, l, i, exp;
            b = c[0]; l = c[1]; i = c[2];
            exp = b & ~l & i;
            hold_req = 1; insn_boundary = 0; lock_active = 0; bus_idle = 1;
            step(2);
            chk("R3 held off without boundary", float_en, 1'b0);
            insn_boundary = b; lock_active = l; bus_idle = i;
            step(1);
            chk(l ? "R4 sweep float" : (!i ? "R5 sweep float" : "R3 sweep float"),
                float_en, exp);
            chk("R6 sweep ack", hold_ack, 1'b0);
            insn_boundary = 0; lock_active = 0; bus_idle = 1;
            if (exp) begin
                step(1); chk("R6 granted ack", hold_ack, 1'b1);
                chk("R6 granted float", float_en, 1'b1);
                lock_active = 1; insn_boundary = 1; bus_idle = 0;
                step(2); chk("R7 lock ignored", hold_ack, 1'b1);
                lock_active = 0; insn_boundary = 0; bus_idle = 1;
                hold_req = 0;
                step(2); chk("R8 ack held edge2", hold_ack, 1'b1);
                step(1); chk("R8 ack falls", hold_ack, 1'b0);
                chk("R8 float held", float_en, 1'b1);
                step(1); chk("R8 float falls", float_en, 1'b0);
            end else begin
                hold_req = 0;
                step(3); chk("R4 R5 stays owned", float_en, 1'b0);
            end
        end

        // R9: request drops so the grant edge is followed by an aborted FLOAT
        hold_req = 1; insn_boundary = 0;
        step(3);
        hold_req = 0;
        step(1);
        insn_boundary = 1;
        step(1); chk("R9 float entered", float_en, 1'b1);
        chk("R9 no ack in float", hold_ack, 1'b0);
        insn_boundary = 0;
        step(1); chk("R9 ack never raised", hold_ack, 1'b0);
        chk("R9 float in reclaim", float_en, 1'b1);
        step(1); chk("R9 float released", float_en, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule